// File: doc/BRIEF.md
# Associative Layer Learning Controller

This block teaches an associative store which class leads to which. Class labels come in pairs, a key first and then a response, each announced by a one-cycle start pulse together with an input weight. For each label the controller reads the class record from the store. A class seen for the first time gets a fresh record holding the input weight and an association index of zero. A class already present is tuned. The controller walks the memory-layer nodes of that class one per cycle, keeps the weight of the node with the largest pattern count, writes that weight back as the class weight and advances the association index by one.

After the response has been recorded, the controller reads the key-to-response arrow weight from the store's side table, which is indexed by response class. It adds one and writes the result in a single arrow write. That write places the weight and the response label in the key's association arrays at the key's index, and also in the side table. A phase input selects learning (1) or recall (0). In recall the controller parks and writes nothing.

Top module: `assoc_learn_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `done` is 1 and `wr_en` is 0, and the next start is handled as a key.
- R2: A label whose store record reads `st_present`=0 produces one record write (`wr_en`=1, `wr_arrow`=0) with `st_class` = label, `st_weight` = the input weight and `st_mx_out` = 0. Handling a new key takes 2 cycles with `done` low.
- R3: For a label whose record is present, `ml_node` steps through 0 to NODES-1 one per cycle. The record write carries the `ml_weight` of the node with the largest `ml_count`; on a tie the lowest node number wins. Handling an existing key takes NODES+2 cycles with `done` low.
- R4: For a present label, the record write carries `st_mx_out` = the stored index plus one, wrapping at the index width.
- R5: Starts alternate between key and response. Only a response is followed by the arrow read and arrow write, which add 2 cycles with `done` low. The next start after that is a key again.
- R6: The arrow write (`wr_en`=1, `wr_arrow`=1) carries `st_class` = key, `st_resp` = response and `st_mx_out` = the index written for the key. It also carries `st_arrow_out` = `st_arrow_w` + 1, where `st_arrow_w` is read with the same class and response. An association with no prior arrow (read 0) therefore gets weight 1.
- R7: `wr_en` is high only in record and arrow write cycles. `done` is high only while waiting for a start. The two are never high together.
- R8: When `phase` is 0 the controller parks: `done` and `wr_en` stay 0 and a pending pair is dropped. One cycle after `phase` returns to 1, `done` is 1 and the next start is a key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 1 | 1 = learning, 0 = recall (parked) |
| start | input | 1 | Accept `class_in` / `weight_in` while `done` is high |
| class_in | input | CW | Class label of the key or response |
| weight_in | input | WW | Input weight used for a new class |
| st_present | input | 1 | Store: presence bit of class `st_class` |
| st_mx | input | MXW | Store: association index of class `st_class` |
| st_arrow_w | input | AW | Store: side-table arrow weight at [`st_class`][`st_resp`] |
| ml_count | input | PW | Memory layer: pattern count of node `ml_node` of the current class |
| ml_weight | input | WW | Memory layer: weight of node `ml_node` of the current class |
| done | output | 1 | Controller waiting for a start |
| wr_en | output | 1 | Store write strobe |
| wr_arrow | output | 1 | 0 = class record write, 1 = arrow write |
| st_class | output | CW | Store class address (read and write) |
| st_resp | output | CW | Response class for the arrow read and write |
| st_weight | output | WW | Class weight to write |
| st_mx_out | output | MXW | Index to write (record) or array slot (arrow) |
| st_arrow_out | output | AW | Arrow weight to write |
| ml_node | output | NW | Memory-layer node being scanned |

## Verification
A wrong role toggle shows within one pair: an arrow write appears after a key, or is missing after a response, and the busy length of the item is off by two cycles. A broken scan register or node counter gives a wrong class weight at the tune write, or a busy length other than NODES+2, seen the moment that class is learned again. A stale arrow or index register shows as a wrong side-table weight or array slot when the same association repeats. The bench compares its store model with an independently computed expectation after every pair.

// File: rtl/assoc_learn_pkg.sv
// Package: shared state encoding of the associative learning controller.
// Assumes: nothing beyond IEEE 1800-2017.
package assoc_learn_pkg;

    typedef enum logic [2:0] {
        ST_PARK   = 3'd0,
        ST_DONE   = 3'd1,
        ST_DETECT = 3'd2,
        ST_CREATE = 3'd3,
        ST_SCAN   = 3'd4,
        ST_TUNE   = 3'd5,
        ST_RDARW  = 3'd6,
        ST_ARROW  = 3'd7
    } ctrl_state_t;

endpackage

// File: rtl/assoc_node_scan.sv
// Module: walks NODES memory-layer nodes, one per step, and keeps the weight
// of the node with the greatest pattern count (earliest node wins ties).
// Assumes: clear is pulsed before the first step of a walk.
module assoc_node_scan #(
    parameter int NODES = 16,
    parameter int PW    = 8,
    parameter int WW    = 8,
    localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [PW-1:0] cnt_in,
    input  logic [WW-1:0] wgt_in,
    output logic [NW-1:0] node_idx,
    output logic          last,
    output logic [WW-1:0] best_wgt
);
    localparam logic [NW-1:0] LAST_IDX = NW'(NODES - 1);

    logic [PW-1:0] best_cnt;
    logic          take;

    // Decide whether the presented node replaces the kept candidate.
    always_comb take = (node_idx == '0) || (cnt_in > best_cnt);

    assign last = (node_idx == LAST_IDX);

    // Node counter and kept-candidate registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            node_idx <= '0;
            best_cnt <= '0;
            best_wgt <= '0;
        end else if (step) begin
            node_idx <= last ? '0 : node_idx + 1'b1;
            if (take) begin
                best_cnt <= cnt_in;
                best_wgt <= wgt_in;
            end
        end
    end

endmodule

// File: rtl/assoc_learn_fsm.sv
// Module: sequencing of key/response handling, the role toggle and parking.
// Assumes: present is the store presence bit for the latched class, valid in
// the detect state; scan_last marks the final node of a walk.
module assoc_learn_fsm
    import assoc_learn_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        phase,
    input  logic        start,
    input  logic        present,
    input  logic        scan_last,
    output ctrl_state_t state,
    output logic        role_resp
);
    ctrl_state_t nxt;
    logic        toggle;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_PARK:   nxt = ST_DONE;
            ST_DONE:   nxt = start ? ST_DETECT : ST_DONE;
            ST_DETECT: nxt = present ? ST_SCAN : ST_CREATE;
            ST_SCAN:   nxt = scan_last ? ST_TUNE : ST_SCAN;
            ST_CREATE: nxt = role_resp ? ST_RDARW : ST_DONE;
            ST_TUNE:   nxt = role_resp ? ST_RDARW : ST_DONE;
            ST_RDARW:  nxt = ST_ARROW;
            ST_ARROW:  nxt = ST_DONE;
            default:   nxt = ST_DONE;
        endcase
    end

    // State register, role toggle and role of the item in hand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_DONE;
            toggle    <= 1'b0;
            role_resp <= 1'b0;
        end else if (!phase) begin
            state     <= ST_PARK;
            toggle    <= 1'b0;
            role_resp <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_DETECT) begin
                role_resp <= toggle;
                toggle    <= ~toggle;
            end
        end
    end

endmodule

// File: rtl/assoc_wr_path.sv
// Module: builds the store address, write data and strobes from the state.
// Assumes: purely combinational; all inputs are registers of the top.
module assoc_wr_path
    import assoc_learn_pkg::*;
#(
    parameter int CW  = 4,
    parameter int WW  = 8,
    parameter int MXW = 4,
    parameter int AW  = 8
) (
    input  ctrl_state_t    state,
    input  logic [CW-1:0]  cls_q,
    input  logic [CW-1:0]  key_cls_q,
    input  logic [WW-1:0]  win_q,
    input  logic [WW-1:0]  best_wgt,
    input  logic [MXW-1:0] mx_rd_q,
    input  logic [MXW-1:0] key_mx_q,
    input  logic [AW-1:0]  arw_q,
    output logic           done,
    output logic           wr_en,
    output logic           wr_arrow,
    output logic [CW-1:0]  st_class,
    output logic [CW-1:0]  st_resp,
    output logic [WW-1:0]  st_weight,
    output logic [MXW-1:0] st_mx_out,
    output logic [AW-1:0]  st_arrow_out
);
    logic arrow_phase;

    // Strobes and addressing per state.
    always_comb begin
        arrow_phase = (state == ST_RDARW) || (state == ST_ARROW);
        done        = (state == ST_DONE);
        wr_en       = (state == ST_CREATE) || (state == ST_TUNE) || (state == ST_ARROW);
        wr_arrow    = (state == ST_ARROW);
        st_class    = arrow_phase ? key_cls_q : cls_q;
        st_resp     = cls_q;
    end

    // Write data per state.
    always_comb begin
        st_weight    = (state == ST_TUNE) ? best_wgt : win_q;
        st_arrow_out = arw_q + 1'b1;
        unique case (state)
            ST_TUNE:  st_mx_out = mx_rd_q + 1'b1;
            ST_ARROW: st_mx_out = key_mx_q;
            default:  st_mx_out = '0;
        endcase
    end

endmodule

// File: rtl/assoc_learn_ctrl.sv
// Module: top of the associative layer learning controller. Latches the
// label and weight at start, captures store reads, and ties the sequencer,
// node scan and write path together.
// Assumes: store and memory-layer reads respond combinationally to
// st_class / st_resp / ml_node within the same cycle.
module assoc_learn_ctrl
    import assoc_learn_pkg::*;
#(
    parameter int CW    = 4,
    parameter int WW    = 8,
    parameter int MXW   = 4,
    parameter int AW    = 8,
    parameter int PW    = 8,
    parameter int NODES = 16,
    localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           phase,
    input  logic           start,
    input  logic [CW-1:0]  class_in,
    input  logic [WW-1:0]  weight_in,
    input  logic           st_present,
    input  logic [MXW-1:0] st_mx,
    input  logic [AW-1:0]  st_arrow_w,
    input  logic [PW-1:0]  ml_count,
    input  logic [WW-1:0]  ml_weight,
    output logic           done,
    output logic           wr_en,
    output logic           wr_arrow,
    output logic [CW-1:0]  st_class,
    output logic [CW-1:0]  st_resp,
    output logic [WW-1:0]  st_weight,
    output logic [MXW-1:0] st_mx_out,
    output logic [AW-1:0]  st_arrow_out,
    output logic [NW-1:0]  ml_node
);
    ctrl_state_t    state;
    logic           role_resp;
    logic           scan_last;
    logic [WW-1:0]  best_wgt;
    logic [CW-1:0]  cls_q;
    logic [CW-1:0]  key_cls_q;
    logic [WW-1:0]  win_q;
    logic [MXW-1:0] mx_rd_q;
    logic [MXW-1:0] key_mx_q;
    logic [AW-1:0]  arw_q;

    assoc_learn_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .start     (start),
        .present   (st_present),
        .scan_last (scan_last),
        .state     (state),
        .role_resp (role_resp)
    );

    assoc_node_scan #(.NODES(NODES), .PW(PW), .WW(WW)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_DETECT),
        .step     (state == ST_SCAN),
        .cnt_in   (ml_count),
        .wgt_in   (ml_weight),
        .node_idx (ml_node),
        .last     (scan_last),
        .best_wgt (best_wgt)
    );

    assoc_wr_path #(.CW(CW), .WW(WW), .MXW(MXW), .AW(AW)) u_wr (
        .state        (state),
        .cls_q        (cls_q),
        .key_cls_q    (key_cls_q),
        .win_q        (win_q),
        .best_wgt     (best_wgt),
        .mx_rd_q      (mx_rd_q),
        .key_mx_q     (key_mx_q),
        .arw_q        (arw_q),
        .done         (done),
        .wr_en        (wr_en),
        .wr_arrow     (wr_arrow),
        .st_class     (st_class),
        .st_resp      (st_resp),
        .st_weight    (st_weight),
        .st_mx_out    (st_mx_out),
        .st_arrow_out (st_arrow_out)
    );

    // Operand capture: label at start, store reads, and the key's record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q     <= '0;
            key_cls_q <= '0;
            win_q     <= '0;
            mx_rd_q   <= '0;
            key_mx_q  <= '0;
            arw_q     <= '0;
        end else begin
            if (state == ST_DONE && start) begin
                cls_q <= class_in;
                win_q <= weight_in;
            end
            if (state == ST_DETECT) mx_rd_q <= st_mx;
            if (state == ST_RDARW)  arw_q   <= st_arrow_w;
            if ((state == ST_CREATE || state == ST_TUNE) && !role_resp) begin
                key_cls_q <= cls_q;
                key_mx_q  <= st_mx_out;
            end
        end
    end

endmodule

// File: rtl/assoc_learn_chk.sv
// Module: port-level properties of the learning controller, bound to the top.
// Assumes: rst_n is held low from time zero until the first edges.
module assoc_learn_chk (
    input logic clk,
    input logic rst_n,
    input logic phase,
    input logic done,
    input logic wr_en,
    input logic wr_arrow
);
    // R7: strobe and done never coincide.
    a_r7_no_wr_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && done));

    // R8: one cycle after recall is seen, the controller is quiet.
    a_r8_park_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |=> (!wr_en && !done));

    // R6: the arrow write is preceded by a cycle without a write (the read).
    a_r6_read_before_arrow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_arrow) |-> $past(!wr_en));

    // R5: the arrow write completes the pair and returns to waiting.
    a_r5_arrow_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_arrow && phase) |=> done);

    // R2: a record write is single-cycle.
    a_r2_record_single: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_arrow && phase) |=> !wr_en);

    // R1: arrow strobe only appears with the write strobe.
    a_r1_arrow_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        wr_arrow |-> wr_en);
endmodule

bind assoc_learn_ctrl assoc_learn_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .done     (done),
    .wr_en    (wr_en),
    .wr_arrow (wr_arrow)
);

// File: tb/assoc_learn_ctrl_tb.sv
module assoc_learn_ctrl_tb;
    localparam int CW = 4, WW = 8, MXW = 4, AW = 8, PW = 8, NODES = 16;
    localparam int NC = 1 << CW;
    localparam int NM = 1 << MXW;

    logic clk = 1'b0, rst_n = 1'b0, phase = 1'b1, start = 1'b0;
    logic [CW-1:0] class_in = '0;
    logic [WW-1:0] weight_in = '0;
    logic st_present;
    logic [MXW-1:0] st_mx;
    logic [AW-1:0] st_arrow_w;
    logic [PW-1:0] ml_count;
    logic [WW-1:0] ml_weight;
    logic done, wr_en, wr_arrow;
    logic [CW-1:0] st_class, st_resp;
    logic [WW-1:0] st_weight;
    logic [MXW-1:0] st_mx_out;
    logic [AW-1:0] st_arrow_out;
    logic [3:0] ml_node;

    always #2 clk = ~clk;

    assoc_learn_ctrl #(.CW(CW), .WW(WW), .MXW(MXW), .AW(AW), .PW(PW), .NODES(NODES)) u_dut (
        .clk(clk), .rst_n(rst_n), .phase(phase), .start(start), .class_in(class_in),
        .weight_in(weight_in), .st_present(st_present), .st_mx(st_mx),
        .st_arrow_w(st_arrow_w), .ml_count(ml_count), .ml_weight(ml_weight),
        .done(done), .wr_en(wr_en), .wr_arrow(wr_arrow), .st_class(st_class),
        .st_resp(st_resp), .st_weight(st_weight), .st_mx_out(st_mx_out),
        .st_arrow_out(st_arrow_out), .ml_node(ml_node));

    // Store model (written by the DUT) and expected model (computed here).
    logic           s_pres [NC];
    logic [WW-1:0]  s_w    [NC];
    logic [MXW-1:0] s_mx   [NC];
    logic [AW-1:0]  s_side [NC][NC];
    logic [AW-1:0]  s_arrw [NC][NM];
    logic [CW-1:0]  s_arrc [NC][NM];
    logic           e_pres [NC];
    logic [WW-1:0]  e_w    [NC];
    logic [MXW-1:0] e_mx   [NC];
    logic [AW-1:0]  e_side [NC][NC];
    int nwr = 0, nrec = 0, narw = 0;
    int tests = 0, fails = 0;

    // Memory-layer stimulus: small count range forces ties.
    function automatic logic [PW-1:0] f_cnt(input int c, input int n);
        return PW'((c * 5 + n * 3 + (n >> 2) + c * n) % 4);
    endfunction
    function automatic logic [WW-1:0] f_wgt(input int c, input int n);
        return WW'((c * 37 + n * 11 + 5) % 256);
    endfunction
    function automatic logic [WW-1:0] f_best(input int c);
        int bc = -1;
        logic [WW-1:0] bw = '0;
        for (int n = 0; n < NODES; n++)
            if (int'(f_cnt(c, n)) > bc) begin bc = int'(f_cnt(c, n)); bw = f_wgt(c, n); end
        return bw;
    endfunction

    always_comb begin
        st_present = s_pres[st_class];
        st_mx      = s_mx[st_class];
        st_arrow_w = s_side[st_class][st_resp];
        ml_count   = f_cnt(int'(st_class), int'(ml_node));
        ml_weight  = f_wgt(int'(st_class), int'(ml_node));
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                s_pres[c] <= 1'b0; s_w[c] <= '0; s_mx[c] <= '0;
                for (int j = 0; j < NC; j++) s_side[c][j] <= '0;
                for (int j = 0; j < NM; j++) begin s_arrw[c][j] <= '0; s_arrc[c][j] <= '0; end
            end
        end else if (wr_en) begin
            nwr <= nwr + 1;
            if (wr_arrow) begin
                narw <= narw + 1;
                s_arrw[st_class][st_mx_out] <= st_arrow_out;
                s_arrc[st_class][st_mx_out] <= st_resp;
                s_side[st_class][st_resp]   <= st_arrow_out;
            end else begin
                nrec <= nrec + 1;
                s_pres[st_class] <= 1'b1;
                s_w[st_class]    <= st_weight;
                s_mx[st_class]   <= st_mx_out;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one label; return number of cycles with done low.
    task automatic item(input int c, input int w, output int busy);
        while (!done) @(negedge clk);
        start = 1'b1; class_in = CW'(c); weight_in = WW'(w);
        @(negedge clk);
        start = 1'b0;
        busy = 0;
        while (!done) begin busy++; @(negedge clk); end
    endtask

    // Expected update of a class record; returns index written.
    function automatic int exp_item(input int c, input int w);
        if (!e_pres[c]) begin
            e_pres[c] = 1'b1; e_w[c] = WW'(w); e_mx[c] = '0;
        end else begin
            e_w[c] = f_best(c); e_mx[c] = e_mx[c] + 1'b1;
        end
        return int'(e_mx[c]);
    endfunction

    task automatic pair(input int k, input int r, input int wk, input int wr);
        int busy, exp_busy, kmx, w0, a0, r0;
        w0 = nwr; a0 = narw; r0 = nrec;
        exp_busy = e_pres[k] ? NODES + 2 : 2;
        item(k, wk, busy);
        kmx = exp_item(k, wk);
        chk(busy == exp_busy, "R5 key busy (R2/R3 length)", busy, exp_busy);
        exp_busy = (e_pres[r] ? NODES + 2 : 2) + 2;
        item(r, wr, busy);
        void'(exp_item(r, wr));
        e_side[k][r] = e_side[k][r] + 1'b1;
        chk(busy == exp_busy, "R5 response busy incl arrow", busy, exp_busy);
        chk(nwr - w0 == 3 && narw - a0 == 1 && nrec - r0 == 2, "R7 writes per pair",
            nwr - w0, 3);
        chk(s_w[k] == e_w[k] && s_pres[k], "R3 key weight", int'(s_w[k]), int'(e_w[k]));
        chk(s_mx[k] == e_mx[k], "R4 key index", int'(s_mx[k]), int'(e_mx[k]));
        chk(s_w[r] == e_w[r] && s_pres[r], "R2 response weight", int'(s_w[r]), int'(e_w[r]));
        chk(s_mx[r] == e_mx[r], "R4 response index", int'(s_mx[r]), int'(e_mx[r]));
        chk(s_side[k][r] == e_side[k][r], "R6 side arrow weight",
            int'(s_side[k][r]), int'(e_side[k][r]));
        chk(s_arrw[k][kmx] == e_side[k][r] && int'(s_arrc[k][kmx]) == r, "R6 arrow slot",
            int'(s_arrw[k][kmx]), int'(e_side[k][r]));
    endtask

    task automatic park_check(input string tag);
        int w0;
        w0 = nwr;
        phase = 1'b0;
        repeat (8) begin
            @(negedge clk);
            chk(!done && !wr_en, tag, int'(done), 0);
        end
        chk(nwr == w0, "R8 no writes while parked", nwr - w0, 0);
        phase = 1'b1;
        @(negedge clk);
        chk(done == 1'b1, "R8 done after return to learning", int'(done), 1);
    endtask

    initial begin
        int busy, kmx, seed_dummy;
        for (int c = 0; c < NC; c++) begin
            e_pres[c] = 1'b0; e_w[c] = '0; e_mx[c] = '0;
            for (int j = 0; j < NC; j++) e_side[c][j] = '0;
        end
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b1 && wr_en == 1'b0, "R1 reset state", int'(done), 1);
        // Directed: fresh pair, arrow starts at 1 (R6, R2).
        pair(3, 5, 17, 90);
        // Repeat: both existing, arrow weight 2 (R3, R4, R6).
        pair(3, 5, 1, 2);
        // Same class as key and response (R4, R6).
        pair(7, 7, 44, 45);
        pair(7, 7, 0, 0);
        // R8: park after a key has been handled.
        item(9, 200, busy);
        kmx = exp_item(9, 200);
        chk(busy == 2, "R2 new key busy", busy, 2);
        park_check("R8 quiet after key");
        // R1/R8: next start is a key again (arrow follows second item only).
        pair(9, 3, 8, 8);
        // R8: park in the middle of a scan; nothing written.
        while (!done) @(negedge clk);
        start = 1'b1; class_in = 4'd3; @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        park_check("R8 quiet mid-scan");
        chk(s_mx[3] == e_mx[3], "R8 aborted scan left record", int'(s_mx[3]), int'(e_mx[3]));
        // Random pairs over a small class set.
        for (int i = 0; i < 40; i++)
            pair(int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
                 int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule